// File: doc/BRIEF.md
# Li-ion Charge State Controller

This block is the sequencing core of a single-cell lithium battery charger. It is a synchronous state machine that takes comparator flags for the battery voltage and charge current, which the analog front end has already turned into digital levels. From these it decides which charge phase is active: precharge, trickle, constant current (CC), constant voltage (CV), top-off or done. Its phase current selection drives the current regulation loop. It also reports a status detail code, a charge-OK bit and a one-cycle interrupt.

The controller guards the charge cycle in three ways. Safety timers bound the time spent in prequalification and in fast charge. A host watchdog halts charging when software stops servicing it. A thermal shutdown flag overrides everything else. All timing counts a shared prescaled tick input, so real-time periods come from the tick rate together with the tick-count parameters and the two programmable limits.

Top module: `li_chg_seq`

## Requirements
- R1: When `in_valid_i` or `chg_en_i` is low, the state is idle (code 0) and `isel_o` is 0 (off). Safety, termination and watchdog counts restart from zero on every leave of idle.
- R2: On leaving idle, the state is precharge (1) if `bat_lt_pre_i` is high. Otherwise it is trickle (2) if `bat_lt_trk_i` and `pq_en_i` are both high, and fast-charge CC (3) if not. Precharge moves to trickle when `bat_lt_pre_i` drops. Trickle moves to CC when `bat_lt_trk_i` drops or `pq_en_i` is low. `isel_o` is 1 in precharge, 2 in trickle, 3 in CC/CV/top-off and 0 in every other state.
- R3: CC moves to CV (4) when `bat_at_reg_i` is high. CV moves to top-off (5) once `i_lt_term_i` has stayed high for TERM_TICKS consecutive ticks. A drop of `i_lt_term_i` restarts that count.
- R4: Top-off moves to done (6) after `to_lim_i` ticks. From top-off or done, a high `bat_lt_rst_i` returns the state to CC, and this return takes precedence over the top-off expiry.
- R5: Timer fault (7) is entered after PQ_TICKS ticks spent across precharge and trickle, or after `fc_lim_i` ticks spent across CC and CV.
- R6: Timer fault is held until `in_valid_i` or `chg_en_i` goes low. That drop returns the state to idle, so charging resumes only after the signal is raised again.
- R7: The watchdog runs only while `wd_en_i` is high. A clear is a `wd_clr_i` strobe with `wd_clr_val_i` equal to 2'b01, and any other value is ignored. After WD_TICKS ticks without a clear, the state becomes watchdog suspend (8). A valid clear in suspend returns the state to idle, from which charging restarts.
- R8: When `thermal_sd_i` is high, the next state is thermal shutdown (9) from any state. `mode_dflt_o` pulses for one cycle on entry. When the flag clears, the state returns to idle. Priority is thermal shutdown, then watchdog expiry, then timer fault, then phase progression.
- R9: `dtls_o` reads 0x0 in precharge and trickle, 0x1 in CC, 0x2 in CV, 0x3 in top-off, 0x4 in done, 0x6 in timer fault, 0x8 in idle, 0xA in thermal shutdown and 0xB in watchdog suspend. `chg_ok_o` is 1 in precharge through top-off and 0 elsewhere.
- R10: For precharge through done, `dtls_o` and `chg_ok_o` change only after the state has been held for SETTLE_TICKS ticks. For idle, timer fault, watchdog suspend and thermal shutdown, they change on the clock edge after entry.
- R11: `irq_o` pulses for exactly one cycle when `chg_ok_o` changes value, and stays low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled time base, one-cycle pulses |
| in_valid_i | input | 1 | Input source qualified as valid |
| chg_en_i | input | 1 | Charging enabled by the mode setting |
| pq_en_i | input | 1 | Prequalification (trickle phase) enable |
| bat_lt_pre_i | input | 1 | Battery below precharge threshold |
| bat_lt_trk_i | input | 1 | Battery below trickle threshold |
| bat_at_reg_i | input | 1 | Battery at regulation voltage |
| i_lt_term_i | input | 1 | Charge current below termination level |
| bat_lt_rst_i | input | 1 | Battery below regulation minus restart margin |
| fc_lim_i | input | CNT_W | Fast-charge time limit in ticks |
| to_lim_i | input | CNT_W | Top-off time in ticks |
| wd_en_i | input | 1 | Watchdog enable |
| wd_clr_i | input | 1 | Watchdog clear write strobe |
| wd_clr_val_i | input | 2 | Value written with the clear strobe |
| thermal_sd_i | input | 1 | Die thermal shutdown flag |
| state_o | output | 4 | Current state code |
| dtls_o | output | 4 | Reported status detail code |
| chg_ok_o | output | 1 | Reported charge-OK bit |
| irq_o | output | 1 | Status-change interrupt pulse |
| isel_o | output | 2 | Charge current selection |
| mode_dflt_o | output | 1 | Request to restore the mode setting to default |

## Verification
The bench targets the timers that span more than one state. A design that restarted the prequalification count on the precharge to trickle step would never fault. A design that kept counting through idle would fault early after a disable and re-enable. Termination pulses shorter than TERM_TICKS with gaps between them must not reach top-off, which catches a counter that only pauses instead of restarting. The bench also checks that timer fault survives flag changes and clears only through the enable or input toggle, and that a clear with the wrong value does not service the watchdog. Reports are checked both ways: during the settle window the old code must still show, and fault codes must appear one edge after entry. The interrupt count is compared with transitions that leave OK unchanged, such as trickle to CC and top-off back to CC.

// File: rtl/li_chg_pkg.sv
package li_chg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_PRE  = 4'd1,
    ST_TRK  = 4'd2,
    ST_CC   = 4'd3,
    ST_CV   = 4'd4,
    ST_TO   = 4'd5,
    ST_DONE = 4'd6,
    ST_TFLT = 4'd7,
    ST_WDS  = 4'd8,
    ST_TSD  = 4'd9
  } chg_st_e;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_PQ   = 2'd1,
    GRP_FC   = 2'd2,
    GRP_TO   = 2'd3
  } tmr_grp_e;

  typedef enum logic [1:0] {
    ISEL_OFF  = 2'd0,
    ISEL_PRE  = 2'd1,
    ISEL_TRK  = 2'd2,
    ISEL_FAST = 2'd3
  } isel_e;

  function automatic logic [3:0] dtls_of(chg_st_e st);
    case (st)
      ST_PRE, ST_TRK: return 4'h0;
      ST_CC:          return 4'h1;
      ST_CV:          return 4'h2;
      ST_TO:          return 4'h3;
      ST_DONE:        return 4'h4;
      ST_TFLT:        return 4'h6;
      ST_TSD:         return 4'hA;
      ST_WDS:         return 4'hB;
      default:        return 4'h8;
    endcase
  endfunction

  function automatic logic ok_of(chg_st_e st);
    return st inside {ST_PRE, ST_TRK, ST_CC, ST_CV, ST_TO};
  endfunction

  // charge phases wait for the settle delay; off and fault states report at once
  function automatic logic needs_settle(chg_st_e st);
    return st inside {ST_PRE, ST_TRK, ST_CC, ST_CV, ST_TO, ST_DONE};
  endfunction

endpackage

// File: rtl/li_chg_timers.sv
module li_chg_timers
  import li_chg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PQ_TICKS   = 1800,
  parameter int TERM_TICKS = 30,
  parameter int WD_TICKS   = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  tmr_grp_e         grp_i,
  input  logic [CNT_W-1:0] fc_lim_i,
  input  logic [CNT_W-1:0] to_lim_i,
  input  logic             term_act_i,
  input  logic             wd_zero_i,
  input  logic             wd_clr_i,
  input  logic             wd_run_i,
  output logic             pq_exp_o,
  output logic             fc_exp_o,
  output logic             to_exp_o,
  output logic             term_exp_o,
  output logic             wd_exp_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] PQ_LIM  = CNT_W'(PQ_TICKS);
  localparam logic [CNT_W-1:0] TRM_LIM = CNT_W'(TERM_TICKS);
  localparam logic [CNT_W-1:0] WD_LIM  = CNT_W'(WD_TICKS);

  tmr_grp_e         grp_q;
  logic [CNT_W-1:0] ph_cnt, term_cnt, wd_cnt;
  logic             grp_same;

  assign grp_same = (grp_i == grp_q) && (grp_i != GRP_NONE);

  // one counter serves whichever phase group is active; a group change restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q  <= GRP_NONE;
      ph_cnt <= '0;
    end else begin
      grp_q <= grp_i;
      if (!grp_same)                       ph_cnt <= '0;
      else if (tick_i && ph_cnt != CNT_MAX) ph_cnt <= ph_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             term_cnt <= '0;
    else if (!term_act_i)                    term_cnt <= '0;
    else if (tick_i && term_cnt != CNT_MAX)  term_cnt <= term_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     wd_cnt <= '0;
    else if (wd_zero_i || wd_clr_i)                  wd_cnt <= '0;
    else if (wd_run_i && tick_i && wd_cnt != CNT_MAX) wd_cnt <= wd_cnt + 1'b1;
  end

  assign pq_exp_o   = grp_same && grp_i == GRP_PQ && ph_cnt >= PQ_LIM;
  assign fc_exp_o   = grp_same && grp_i == GRP_FC && ph_cnt >= fc_lim_i;
  assign to_exp_o   = grp_same && grp_i == GRP_TO && ph_cnt >= to_lim_i;
  assign term_exp_o = term_act_i && term_cnt >= TRM_LIM;
  assign wd_exp_o   = wd_cnt >= WD_LIM;

  AST_GRP_CHANGE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_i != grp_q) |=> !pq_exp_o && !fc_exp_o && !to_exp_o || (ph_cnt == '0)); // R1
  AST_WD_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_zero_i |=> (wd_cnt == '0)); // R1
  AST_TERM_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_exp_o |-> $past(term_act_i)); // R3

endmodule

// File: rtl/li_chg_report.sv
module li_chg_report
  import li_chg_pkg::*;
#(
  parameter int SETTLE_TICKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  chg_st_e    state_i,
  output logic [3:0] dtls_o,
  output logic       chg_ok_o,
  output logic       irq_o
);

  localparam int SW = $clog2(SETTLE_TICKS + 1) + 1;
  localparam logic [SW-1:0] S_LIM = SW'(SETTLE_TICKS);

  chg_st_e       st_q;
  logic [SW-1:0] scnt;
  logic          upd, nxt_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      scnt <= '0;
    end else begin
      st_q <= state_i;
      if (state_i != st_q)             scnt <= '0;
      else if (tick_i && scnt < S_LIM) scnt <= scnt + 1'b1;
    end
  end

  assign upd    = !needs_settle(state_i) || (state_i == st_q && scnt >= S_LIM);
  assign nxt_ok = ok_of(state_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dtls_o   <= 4'h8;
      chg_ok_o <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= upd && (nxt_ok != chg_ok_o);
      if (upd) begin
        dtls_o   <= dtls_of(state_i);
        chg_ok_o <= nxt_ok;
      end
    end
  end

  AST_IRQ_ON_OK_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (chg_ok_o != $past(chg_ok_o))); // R11
  AST_OK_CHANGE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_ok_o != $past(chg_ok_o)) |-> irq_o); // R11
  AST_FAULT_REPORT_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_TFLT && $past(state_i) == ST_TFLT) |-> (dtls_o == 4'h6 && !chg_ok_o)); // R10
  AST_SETTLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (needs_settle(state_i) && state_i != st_q) |=> $stable(dtls_o)); // R10

endmodule

// File: rtl/li_chg_seq.sv
module li_chg_seq
  import li_chg_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int PQ_TICKS     = 1800,
  parameter int TERM_TICKS   = 30,
  parameter int WD_TICKS     = 80,
  parameter int SETTLE_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             in_valid_i,
  input  logic             chg_en_i,
  input  logic             pq_en_i,
  input  logic             bat_lt_pre_i,
  input  logic             bat_lt_trk_i,
  input  logic             bat_at_reg_i,
  input  logic             i_lt_term_i,
  input  logic             bat_lt_rst_i,
  input  logic [CNT_W-1:0] fc_lim_i,
  input  logic [CNT_W-1:0] to_lim_i,
  input  logic             wd_en_i,
  input  logic             wd_clr_i,
  input  logic [1:0]       wd_clr_val_i,
  input  logic             thermal_sd_i,
  output logic [3:0]       state_o,
  output logic [3:0]       dtls_o,
  output logic             chg_ok_o,
  output logic             irq_o,
  output logic [1:0]       isel_o,
  output logic             mode_dflt_o
);

  chg_st_e  state_q, state_d;
  tmr_grp_e grp;
  isel_e    isel;
  logic     pq_exp, fc_exp, to_exp, term_exp, wd_cnt_exp;
  logic     wd_clr_ok, wd_exp, src_ok;

  assign wd_clr_ok = wd_clr_i && (wd_clr_val_i == 2'b01);
  assign wd_exp    = wd_en_i && wd_cnt_exp;
  assign src_ok    = in_valid_i && chg_en_i;

  always_comb begin
    case (state_q)
      ST_PRE, ST_TRK: grp = GRP_PQ;
      ST_CC, ST_CV:   grp = GRP_FC;
      ST_TO:          grp = GRP_TO;
      default:        grp = GRP_NONE;
    endcase
  end

  li_chg_timers #(
    .CNT_W      (CNT_W),
    .PQ_TICKS   (PQ_TICKS),
    .TERM_TICKS (TERM_TICKS),
    .WD_TICKS   (WD_TICKS)
  ) i_timers (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .grp_i      (grp),
    .fc_lim_i   (fc_lim_i),
    .to_lim_i   (to_lim_i),
    .term_act_i (state_q == ST_CV && i_lt_term_i),
    .wd_zero_i  (state_q == ST_IDLE || !wd_en_i),
    .wd_clr_i   (wd_clr_ok),
    .wd_run_i   (state_q != ST_WDS && state_q != ST_TSD),
    .pq_exp_o   (pq_exp),
    .fc_exp_o   (fc_exp),
    .to_exp_o   (to_exp),
    .term_exp_o (term_exp),
    .wd_exp_o   (wd_cnt_exp)
  );

  // priority: thermal, source loss, watchdog, safety timer, phase progression
  always_comb begin
    state_d = state_q;
    if (thermal_sd_i) begin
      state_d = ST_TSD;
    end else if (state_q == ST_TSD) begin
      state_d = ST_IDLE;
    end else if (state_q == ST_IDLE) begin
      if (src_ok) begin
        if (bat_lt_pre_i)                  state_d = ST_PRE;
        else if (bat_lt_trk_i && pq_en_i)  state_d = ST_TRK;
        else                               state_d = ST_CC;
      end
    end else if (!src_ok) begin
      state_d = ST_IDLE;
    end else if (state_q == ST_WDS) begin
      if (wd_clr_ok) state_d = ST_IDLE;
    end else if (wd_exp) begin
      state_d = ST_WDS;
    end else if (pq_exp || fc_exp) begin
      state_d = ST_TFLT;
    end else begin
      case (state_q)
        ST_PRE:  if (!bat_lt_pre_i)             state_d = ST_TRK;
        ST_TRK:  if (!bat_lt_trk_i || !pq_en_i) state_d = ST_CC;
        ST_CC:   if (bat_at_reg_i)              state_d = ST_CV;
        ST_CV:   if (term_exp)                  state_d = ST_TO;
        ST_TO: begin
          if (bat_lt_rst_i)   state_d = ST_CC;
          else if (to_exp)    state_d = ST_DONE;
        end
        ST_DONE: if (bat_lt_rst_i)              state_d = ST_CC;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mode_dflt_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      mode_dflt_o <= (state_d == ST_TSD) && (state_q != ST_TSD);
    end
  end

  always_comb begin
    case (state_q)
      ST_PRE:               isel = ISEL_PRE;
      ST_TRK:               isel = ISEL_TRK;
      ST_CC, ST_CV, ST_TO:  isel = ISEL_FAST;
      default:              isel = ISEL_OFF;
    endcase
  end

  assign state_o = state_q;
  assign isel_o  = isel;

  li_chg_report #(
    .SETTLE_TICKS (SETTLE_TICKS)
  ) i_report (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .state_i  (state_q),
    .dtls_o   (dtls_o),
    .chg_ok_o (chg_ok_o),
    .irq_o    (irq_o)
  );

  AST_THERMAL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_sd_i |=> (state_q == ST_TSD)); // R8
  AST_TFLT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TFLT && src_ok && !thermal_sd_i && !wd_exp) |=> (state_q == ST_TFLT)); // R6
  AST_TFLT_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TFLT && $past(state_q) != ST_TFLT)
      |-> ($past(state_q) inside {ST_PRE, ST_TRK, ST_CC, ST_CV})); // R5
  AST_TO_FROM_CV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TO && $past(state_q) != ST_TO) |-> ($past(state_q) == ST_CV)); // R3
  AST_DFLT_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_dflt_o |-> (state_q == ST_TSD && $past(state_q) != ST_TSD)); // R8
  AST_NO_SRC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_ok && !thermal_sd_i && state_q != ST_TSD) |=> (state_q == ST_IDLE)); // R1

endmodule

// File: tb/test_li_chg_seq.sv
module test_li_chg_seq;

  localparam int CNT_W = 16;
  localparam int PQ_T  = 40;
  localparam int TRM_T = 4;
  localparam int WD_T  = 30;
  localparam int STL_T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b1, chg_en = 1'b0, pq_en = 1'b1;
  logic lt_pre = 1'b0, lt_trk = 1'b0, at_reg = 1'b0, lt_term = 1'b0, lt_rst = 1'b0;
  logic [CNT_W-1:0] fc_lim = 16'd1000, to_lim = 16'd30;
  logic wd_en = 1'b0, wd_clr = 1'b0, thermal = 1'b0;
  logic [1:0] wd_val = 2'b00;
  logic [3:0] state, dtls;
  logic ok, irq, mode_dflt;
  logic [1:0] isel;

  int n_chk = 0, n_bad = 0, irq_cnt = 0, dflt_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  li_chg_seq #(
    .CNT_W(CNT_W), .PQ_TICKS(PQ_T), .TERM_TICKS(TRM_T), .WD_TICKS(WD_T), .SETTLE_TICKS(STL_T)
  ) i_li_chg_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .in_valid_i(in_valid), .chg_en_i(chg_en),
    .pq_en_i(pq_en), .bat_lt_pre_i(lt_pre), .bat_lt_trk_i(lt_trk), .bat_at_reg_i(at_reg),
    .i_lt_term_i(lt_term), .bat_lt_rst_i(lt_rst), .fc_lim_i(fc_lim), .to_lim_i(to_lim),
    .wd_en_i(wd_en), .wd_clr_i(wd_clr), .wd_clr_val_i(wd_val), .thermal_sd_i(thermal),
    .state_o(state), .dtls_o(dtls), .chg_ok_o(ok), .irq_o(irq), .isel_o(isel),
    .mode_dflt_o(mode_dflt)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (mode_dflt) dflt_cnt++;
  end

  // flags: lt_pre lt_trk at_reg lt_term lt_rst
  typedef struct packed {
    logic [4:0] flags;
    logic [7:0] wait_c;
    logic [3:0] st;
    logic       ok;
    logic [3:0] dt;
    logic [1:0] is;
    logic [1:0] n_irq;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{5'b11000, 8'd10, 4'd1, 1'b1, 4'h0, 2'd1, 2'd1}, // precharge  R2
    '{5'b01000, 8'd10, 4'd2, 1'b1, 4'h0, 2'd2, 2'd0}, // trickle    R2
    '{5'b00000, 8'd10, 4'd3, 1'b1, 4'h1, 2'd3, 2'd0}, // CC         R2
    '{5'b00100, 8'd10, 4'd4, 1'b1, 4'h2, 2'd3, 2'd0}, // CV         R3
    '{5'b00110, 8'd14, 4'd5, 1'b1, 4'h3, 2'd3, 2'd0}, // top-off    R3
    '{5'b00110, 8'd40, 4'd6, 1'b0, 4'h4, 2'd0, 2'd1}, // done       R4
    '{5'b00001, 8'd10, 4'd3, 1'b1, 4'h1, 2'd3, 2'd1}, // restart    R4
    '{5'b00100, 8'd10, 4'd4, 1'b1, 4'h2, 2'd3, 2'd0}, // CV again   R3
    '{5'b00110, 8'd14, 4'd5, 1'b1, 4'h3, 2'd3, 2'd0}, // top-off    R3
    '{5'b00001, 8'd10, 4'd3, 1'b1, 4'h1, 2'd3, 2'd0}  // TO to CC   R4
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_flags(input logic [4:0] f);
    {lt_pre, lt_trk, at_reg, lt_term, lt_rst} = f;
  endtask

  task automatic wd_write(input logic [1:0] v);
    wd_val = v; wd_clr = 1'b1;
    cyc(1);
    wd_clr = 1'b0;
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      report();
    end
  end

  initial begin
    int i0;
    cyc(3);
    chk("R9", "reset state", state, 0);
    chk("R9", "reset dtls", dtls, 8);
    chk("R9", "reset ok", ok, 0);
    chk("R11", "reset irq", irq, 0);
    chk("R1", "reset isel", isel, 0);
    rst_n = 1'b1;
    cyc(5);
    chk("R1", "disabled idle", state, 0);
    chk("R1", "disabled isel", isel, 0);

    // vector walk through a full charge cycle
    chg_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      i0 = irq_cnt;
      set_flags(VEC[k].flags);
      cyc(int'(VEC[k].wait_c));
      chk("R2", $sformatf("vec%0d state", k), state, VEC[k].st);
      chk("R9", $sformatf("vec%0d ok", k), ok, VEC[k].ok);
      chk("R9", $sformatf("vec%0d dtls", k), dtls, VEC[k].dt);
      chk("R2", $sformatf("vec%0d isel", k), isel, VEC[k].is);
      chk("R11", $sformatf("vec%0d irq count", k), irq_cnt - i0, VEC[k].n_irq);
    end

    // R1 idle restarts the prequalification timer; R5 fault after PQ_T ticks
    chg_en = 1'b0; set_flags(5'b11000);
    cyc(3);
    chk("R1", "disable to idle", state, 0);
    chk("R10", "idle reported at once", dtls, 8);
    chg_en = 1'b1; cyc(30);
    chg_en = 1'b0; cyc(2);
    chg_en = 1'b1; cyc(30);
    chk("R1", "pq timer restarted", state, 1);
    for (int k = 0; k < 20 && state != 4'd7; k++) cyc(1);
    chk("R5", "prequal timeout", state, 7);
    cyc(1);
    chk("R10", "fault dtls next edge", dtls, 6);
    chk("R10", "fault ok cleared", ok, 0);
    chk("R11", "fault irq", irq, 1);
    chk("R2", "fault isel off", isel, 0);

    // R6 fault latched until source toggles
    set_flags(5'b00000);
    cyc(10);
    chk("R6", "fault held", state, 7);
    in_valid = 1'b0; cyc(2);
    chk("R6", "input removal clears", state, 0);
    in_valid = 1'b1; cyc(3);
    chk("R6", "recharge after reapply", state, 3);

    // R3 termination count restarts on a drop
    at_reg = 1'b1; cyc(5);
    chk("R3", "CV reached", state, 4);
    for (int k = 0; k < 3; k++) begin
      lt_term = 1'b1; cyc(3);
      lt_term = 1'b0; cyc(1);
    end
    chk("R3", "short term pulses ignored", state, 4);

    // R5 fast-charge timeout across CC+CV
    fc_lim = 16'd20; cyc(12);
    chk("R5", "fast-charge timeout", state, 7);
    fc_lim = 16'd1000;
    chg_en = 1'b0; cyc(2);
    set_flags(5'b00000);
    chg_en = 1'b1; cyc(3);
    chk("R6", "mode toggle clears fault", state, 3);

    // R7 watchdog
    wd_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc(20);
      wd_write(2'b01);
    end
    chk("R7", "serviced watchdog keeps charging", state, 3);
    cyc(20); wd_write(2'b10);
    cyc(20);
    chk("R7", "wrong clear value ignored", state, 8);
    chk("R9", "suspend dtls", dtls, 11);
    chk("R9", "suspend ok", ok, 0);
    chk("R7", "suspend isel", isel, 0);
    wd_write(2'b01);
    cyc(2);
    chk("R7", "clear restarts charge", state, 3);

    // R8 thermal shutdown wins over watchdog suspend
    cyc(40);
    chk("R7", "second expiry", state, 8);
    i0 = dflt_cnt;
    thermal = 1'b1; cyc(1);
    chk("R8", "thermal entry", state, 9);
    chk("R8", "mode default pulse", mode_dflt, 1);
    cyc(1);
    chk("R9", "thermal dtls", dtls, 10);
    chk("R8", "single default pulse", dflt_cnt - i0, 1);
    thermal = 1'b0; wd_en = 1'b0; cyc(3);
    chk("R8", "recovers through idle", state, 3);
    thermal = 1'b1; cyc(1);
    chk("R8", "thermal from CC", state, 9);
    thermal = 1'b0;

    // R2 prequalification disable, R10 settle window
    chg_en = 1'b0; set_flags(5'b01000); pq_en = 1'b0; cyc(2);
    chg_en = 1'b1; cyc(3);
    chk("R2", "pq disabled enters CC", state, 3);
    chg_en = 1'b0; pq_en = 1'b1; cyc(2);
    chg_en = 1'b1; cyc(10);
    chk("R2", "trickle entry", state, 2);
    i0 = irq_cnt;
    pq_en = 1'b0; cyc(3);
    chk("R2", "pq clear moves to CC", state, 3);
    chk("R10", "dtls held during settle", dtls, 0);
    cyc(6);
    chk("R10", "dtls after settle", dtls, 1);
    chk("R11", "no irq when ok unchanged", irq_cnt - i0, 0);

    finished = 1'b1;
    report();
  end

endmodule